// File: doc/BRIEF.md
# Delayed Write Parity Check Responder

This block sits on the target side of one bus bridge interface. It answers non-posted write attempts that the bridge would otherwise handle as delayed transactions. For each such attempt it checks even parity over the multiplexed address/data lines, the byte-enable lines and the parity bit that follows them. It then chooses one of three answers.

- When the data is clean and no matching request is stored, it retries the initiator and asks the queue to accept a new delayed write request.
- When the data is clean and the attempt repeats a stored request, it completes the data phase and asks the queue to retire the stored completion.
- When parity fails and error response is enabled, it completes the failing data phase, reports the error to the initiator and discards the attempt. Nothing is queued and nothing is retired, even when the attempt looks like a repeat.

A sticky status bit records every parity failure. Software clears it with a write-one-to-clear pulse.

Each attempt begins with an address-phase strobe that carries a delayed-write qualifier and a match indication. The first data phase follows. The parity bit arrives one clock after that data phase. The block answers two clocks after the data phase for exactly one clock, then returns to idle.

Top module: `dw_parity_responder`

## Requirements
- R1: After reset, tgt_ready, tgt_stop, perr_out, enq_req and retire_req are 0 and stat_det_perr is 0.
- R2: Data is presented in the first cycle in which ini_valid is high after an accepted address phase. bus_par is sampled in the next cycle. A parity failure means the XOR of bus_ad, bus_be and bus_par is 1; an even count of ones is clean.
- R3: On a parity failure with perr_resp_en high, tgt_ready is 1 in the response cycle, two clocks after the data phase. In that cycle tgt_stop equals the inverse of ini_last as it was sampled with the data. Both are 0 in the following cycle.
- R4: perr_out is 1 for exactly the response cycle of a failing attempt, and only when perr_resp_en is high. Otherwise it stays 0.
- R5: Every parity failure sets stat_det_perr, whatever perr_resp_en is. The bit is visible from the response cycle and stays set until it is cleared.
- R6: A one-cycle stat_clr pulse clears stat_det_perr. A parity failure that sets the bit in the same cycle wins over the clear.
- R7: A failing attempt with perr_resp_en high raises neither enq_req nor retire_req.
- R8: A clean attempt whose match_hit was 0 at its address phase is retried: tgt_stop is 1 and tgt_ready is 0 in the response cycle, and enq_req pulses in that cycle.
- R9: A clean attempt whose match_hit was 1 completes: tgt_ready is 1, tgt_stop is the inverse of ini_last, and retire_req pulses in the response cycle.
- R10: With perr_resp_en low, a failing attempt is answered exactly as a clean one (R8, R9), with no perr_out.
- R11: A failing attempt with match_hit 1 and perr_resp_en high is answered as in R3 and never raises retire_req.
- R12: An address phase with dly_write low is ignored. No output changes for that attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_phase | input | 1 | Address phase strobe of a new attempt |
| dly_write | input | 1 | Attempt is a delayed-handled write (qualifies addr_phase) |
| match_hit | input | 1 | Attempt matches an already queued request (sampled with addr_phase) |
| ini_valid | input | 1 | Initiator data valid |
| ini_last | input | 1 | Current data phase is the initiator's last |
| bus_ad | input | 32 | Multiplexed address/data lines |
| bus_be | input | 4 | Byte-enable lines |
| bus_par | input | 1 | Parity bit, one clock after its data phase |
| perr_resp_en | input | 1 | Parity error response enable for this interface |
| stat_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| tgt_ready | output | 1 | Target ready |
| tgt_stop | output | 1 | Target stop |
| perr_out | output | 1 | Parity error report to the initiator |
| stat_det_perr | output | 1 | Sticky detected-parity-error status |
| enq_req | output | 1 | Request to queue a new delayed write |
| retire_req | output | 1 | Request to retire the stored completion |

## Verification
Random attempts mix clean and corrupted parity, match and no match, last and burst data phases, and enable on and off. This separates the four possible answers: retry with enqueue, completion with retire, error completion, and an error that is ignored but still recorded. Directed cases cover the combination of a match with an error, which must not retire. Further directed cases cover a clear that lands in the same cycle as a set, and a non-delayed command that must draw no response. Patterns with a single flipped bit, in the data lines or in the byte enables, show that both groups of lines take part in the parity.

// File: rtl/dw_parity_responder.sv
module dw_parity_responder #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_phase,
  input  logic              dly_write,
  input  logic              match_hit,
  input  logic              ini_valid,
  input  logic              ini_last,
  input  logic [DATA_W-1:0] bus_ad,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic              bus_par,
  input  logic              perr_resp_en,
  input  logic              stat_clr,
  output logic              tgt_ready,
  output logic              tgt_stop,
  output logic              perr_out,
  output logic              stat_det_perr,
  output logic              enq_req,
  output logic              retire_req
);
  localparam int BE_W  = DATA_W / 8;
  localparam int CHK_W = DATA_W + BE_W;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PAR, S_RESP} st_t;

  st_t              st;
  logic [CHK_W-1:0] chk_q;
  logic             last_q, match_q, err_q, en_q, stat_q;
  logic             par_bad, in_resp, drop;

  assign par_bad = ^{chk_q, bus_par};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      chk_q   <= '0;
      last_q  <= 1'b0;
      match_q <= 1'b0;
      err_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (addr_phase && dly_write) begin
          st      <= S_WAIT;
          match_q <= match_hit;
        end
        S_WAIT: if (ini_valid) begin
          chk_q  <= {bus_be, bus_ad};
          last_q <= ini_last;
          st     <= S_PAR;
        end
        S_PAR: begin
          err_q <= par_bad;
          en_q  <= perr_resp_en;
          st    <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      stat_q <= 1'b0;
    else if (st == S_PAR && par_bad) stat_q <= 1'b1;
    else if (stat_clr)               stat_q <= 1'b0;
  end

  assign in_resp       = (st == S_RESP);
  assign drop          = in_resp & err_q & en_q;
  assign tgt_ready     = in_resp & (drop | match_q);
  assign tgt_stop      = in_resp & ((drop | match_q) ? ~last_q : 1'b1);
  assign perr_out      = drop;
  assign enq_req       = in_resp & ~drop & ~match_q;
  assign retire_req    = in_resp & ~drop & match_q;
  assign stat_det_perr = stat_q;
endmodule

module dw_parity_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic stat_clr,
  input logic tgt_ready,
  input logic tgt_stop,
  input logic perr_out,
  input logic stat_det_perr,
  input logic enq_req,
  input logic retire_req
);
  assert_resp_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_ready || tgt_stop) |=> !(tgt_ready || tgt_stop));
  assert_perr_with_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    perr_out |-> tgt_ready);
  assert_perr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    perr_out |=> !perr_out);
  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_det_perr && !stat_clr) |=> stat_det_perr);
  assert_no_queue_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    perr_out |-> !(enq_req || retire_req));
  assert_enq_is_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enq_req |-> (tgt_stop && !tgt_ready));
  assert_retire_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_req |-> (tgt_ready && !perr_out));
  assert_single_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({enq_req, retire_req, perr_out}) <= 1);
endmodule

bind dw_parity_responder dw_parity_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr), .tgt_ready(tgt_ready),
  .tgt_stop(tgt_stop), .perr_out(perr_out), .stat_det_perr(stat_det_perr),
  .enq_req(enq_req), .retire_req(retire_req)
);

// File: tb/dw_parity_responder_tb.sv
module dw_parity_responder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_phase = 0, dly_write = 0, match_hit = 0, ini_valid = 0, ini_last = 0;
  logic [31:0] bus_ad = '0;
  logic [3:0]  bus_be = '0;
  logic bus_par = 0, perr_resp_en = 0, stat_clr = 0;
  logic tgt_ready, tgt_stop, perr_out, stat_det_perr, enq_req, retire_req;
  int   n_chk = 0, n_err = 0;
  logic stat_m = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  dw_parity_responder u_dut (.*);

  function automatic logic [5:0] pack(logic r, logic s, logic p, logic e, logic t);
    return {r, s, p, e, t, 1'b0};
  endfunction

  function automatic logic [5:0] exp_resp(logic bad, logic en, logic m, logic last);
    logic drop = bad & en;
    if (drop)   return pack(1'b1, ~last, 1'b1, 1'b0, 1'b0);
    if (m)      return pack(1'b1, ~last, 1'b0, 1'b0, 1'b1);
    return pack(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return pack(tgt_ready, tgt_stop, perr_out, enq_req, retire_req);
  endfunction

  task automatic attempt(string req, logic dly, logic m, logic [31:0] ad, logic [3:0] be,
                         logic bad, logic last, logic en, logic clr_same);
    @(negedge clk);
    addr_phase = 1; dly_write = dly; match_hit = m; ini_valid = 0;
    @(negedge clk);
    addr_phase = 0; match_hit = 0; ini_valid = 1; bus_ad = ad; bus_be = be; ini_last = last;
    @(negedge clk);
    bus_par = (^{ad, be}) ^ bad;
    perr_resp_en = en;
    stat_clr = clr_same;
    @(negedge clk);
    stat_clr = 0;
    if (dly && bad) stat_m = 1;
    else if (clr_same) stat_m = 0;
    check({req, " resp"}, {26'd0, outs()}, dly ? {26'd0, exp_resp(bad, en, m, last)} : 32'd0);
    check({req, " R5 status"}, {31'd0, stat_det_perr}, {31'd0, stat_m});
    @(negedge clk);
    ini_valid = 0;
    check({req, " R3 after"}, {26'd0, outs()}, 32'd0);
  endtask

  task automatic clear_status();
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0; stat_m = 0;
    check("R6 clear", {31'd0, stat_det_perr}, 32'd0);
  endtask

  initial begin
    #200000000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset outs", {26'd0, outs()}, 32'd0);
    check("R1 reset status", {31'd0, stat_det_perr}, 32'd0);
    rst_n = 1;
    attempt("R8 clean retry", 1, 0, 32'h1234_5678, 4'hf, 0, 1, 1, 0);
    attempt("R9 clean retire burst", 1, 1, 32'hdead_beef, 4'h3, 0, 0, 1, 0);
    attempt("R3 R7 err burst", 1, 0, 32'h0000_0001, 4'h0, 1, 0, 1, 0);
    attempt("R2 R4 err last", 1, 0, 32'h0, 4'h1, 1, 1, 1, 0);
    clear_status();
    attempt("R11 err repeat match", 1, 1, 32'hffff_0000, 4'h8, 1, 1, 1, 0);
    attempt("R10 err disabled", 1, 0, 32'h8000_0000, 4'h0, 1, 1, 0, 0);
    attempt("R10 err disabled match", 1, 1, 32'h7, 4'h2, 1, 0, 0, 0);
    attempt("R6 clear loses to set", 1, 0, 32'h5, 4'h5, 1, 1, 1, 1);
    clear_status();
    attempt("R12 ignored cmd", 0, 0, 32'h1, 4'h0, 1, 1, 1, 0);
    check("R12 status untouched", {31'd0, stat_det_perr}, 32'd0);
    for (int i = 0; i < 300; i++) begin
      logic bad = ($urandom % 3) == 0;
      attempt("R2 random", ($urandom % 8) != 0, $urandom % 2, $urandom, $urandom % 16,
              bad, $urandom % 2, ($urandom % 4) != 0, ($urandom % 10) == 0);
      if (($urandom % 16) == 0) clear_status();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule